// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces the periodic event of a PC-style real-time clock. A 32.768 kHz time base arrives as a one-cycle enable strobe on the system clock. A free-running counter counts those strobes. A 4-bit rate code selects a power-of-two period. On every strobe that brings the counter onto a whole multiple of the selected period, the block emits a one-cycle event. The same cycle can also carry a pair of status-flag set strobes and a square-wave pulse.

The rate code and the two enable bits come from the surrounding register file as plain inputs. They are captured on a configuration write strobe. Because events are tied to multiples of the free-running count, a new setting is aligned to that count at once, and the counter itself is never restarted.

Top module: `periodic_rate_gen`

## Requirements
- R1: During and after a synchronous reset the free-running count restarts from zero, all outputs are low, the stored rate code is 6 and both enables are clear. With that reset configuration no event occurs.
- R2: A stored rate code of 0 produces no event, whatever the enables are.
- R3: For a rate code c from 3 to 15, the period is 2^(c-1) time-base ticks.
- R4: Rate codes 1 and 2 give the same periods as codes 8 and 9 (128 and 256 ticks).
- R5: An event occurs on exactly those ticks that bring the tick count since reset onto a multiple of the period. The count wraps at 2^15.
- R6: With a nonzero code but both the interrupt enable and the square-wave enable clear, no event occurs.
- R7: In an event cycle with the interrupt enable set, `flag_set_o` is 2'b11: bit 1 sets the summary interrupt flag and bit 0 sets the periodic flag. Otherwise it is 2'b00.
- R8: In an event cycle with the square-wave enable set, `sqw_pulse_o` is high for that one cycle only. Otherwise it is low.
- R9: A configuration write changes the period and the enables without restarting the count. The next event falls on the next multiple of the new period.
- R10: Outputs are high only in the cycle right after an accepted tick, and for one cycle only.
- R11: When a tick and a configuration write occur in the same cycle, that tick is judged with the settings held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick32_i | input | 1 | One-cycle strobe per 32.768 kHz time-base period |
| cfg_wr_i | input | 1 | Captures rate_i, pie_en_i and sqw_en_i |
| rate_i | input | 4 | Rate-select code |
| pie_en_i | input | 1 | Periodic interrupt enable |
| sqw_en_i | input | 1 | Square-wave pulse enable |
| evt_o | output | 1 | One-cycle periodic event |
| flag_set_o | output | 2 | Set strobes: bit 1 summary interrupt flag, bit 0 periodic flag |
| sqw_pulse_o | output | 1 | One-cycle square-wave pulse |

## Verification
The case hardest to reach from the ports is a change of rate in the middle of a running count. Only this case shows that the next event is aligned to the continuing count and not to the moment of the write. The stimulus table is therefore walked without any reset between rows, so every new row starts at an arbitrary residue of the previous period. The longest period, 16384 ticks, is also run past one full boundary. Directed tests add a write that lands in the same cycle as an event-producing tick, and a reset issued in the middle of a period.

// File: rtl/periodic_rate_pkg.sv
package periodic_rate_pkg;

    localparam int RATE_W  = 4;
    // largest period exponent is (2**RATE_W - 1) - 1
    localparam int MAX_EXP = (1 << RATE_W) - 2;
    // counter wraps on a multiple of the longest period
    localparam int CNT_W   = MAX_EXP + 1;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              pie;
        logic              sqw;
    } rate_cfg_t;

    typedef struct packed {
        rate_cfg_t  cfg;
        logic       evt;
        logic [1:0] flags;
        logic       sqw_p;
    } gen_state_t;

endpackage

// File: rtl/periodic_rate_decode.sv
module periodic_rate_decode
    import periodic_rate_pkg::*;
#(
    parameter int FOLD_MAX = 2,
    parameter int FOLD_ADD = 7
) (
    input  logic [RATE_W-1:0] rate_i,
    output logic [CNT_W-1:0]  mask_o,
    output logic              active_o
);

    localparam int EFF_W = RATE_W + 1;

    logic [EFF_W-1:0] eff_code;
    logic [EFF_W-1:0] exp_val;

    always_comb begin
        eff_code = EFF_W'(rate_i);
        if (rate_i != '0 && int'(rate_i) <= FOLD_MAX) begin
            eff_code = EFF_W'(int'(rate_i) + FOLD_ADD);
        end
        active_o = (rate_i != '0);
        exp_val  = active_o ? (eff_code - EFF_W'(1)) : '0;
    end

    // low exp_val bits of the mask set: period minus one
    for (genvar b = 0; b < CNT_W; b++) begin : g_mask
        assign mask_o[b] = active_o && (int'(exp_val) > b);
    end

endmodule

// File: rtl/periodic_rate_divider.sv
module periodic_rate_divider
    import periodic_rate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] mask_i,
    output logic             hit_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = cnt_q + CNT_W'(1);
        cnt_d   = cnt_q;
        if (tick_i) begin
            cnt_d = cnt_inc;
        end
        hit_o = tick_i && ((cnt_inc & mask_i) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q)); // R10
    AST_HIT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> ((cnt_q & $past(mask_i)) == '0)); // R5

endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen
    import periodic_rate_pkg::*;
#(
    parameter logic [3:0] RESET_RATE = 4'd6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick32_i,
    input  logic       cfg_wr_i,
    input  logic [3:0] rate_i,
    input  logic       pie_en_i,
    input  logic       sqw_en_i,
    output logic       evt_o,
    output logic [1:0] flag_set_o,
    output logic       sqw_pulse_o
);

    gen_state_t       st_d, st_q;
    logic [CNT_W-1:0] mask;
    logic             active;
    logic             hit;
    logic             running;

    periodic_rate_decode #(
        .FOLD_MAX (2),
        .FOLD_ADD (7)
    ) u_decode (
        .rate_i   (st_q.cfg.rate),
        .mask_o   (mask),
        .active_o (active)
    );

    periodic_rate_divider u_div (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick32_i),
        .mask_i (mask),
        .hit_o  (hit)
    );

    always_comb begin
        st_d    = st_q;
        running = active && (st_q.cfg.pie || st_q.cfg.sqw);
        if (cfg_wr_i) begin
            st_d.cfg.rate = rate_i;
            st_d.cfg.pie  = pie_en_i;
            st_d.cfg.sqw  = sqw_en_i;
        end
        st_d.evt   = hit && running;
        st_d.flags = {2{hit && active && st_q.cfg.pie}};
        st_d.sqw_p = hit && active && st_q.cfg.sqw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cfg.rate <= RESET_RATE;
            st_q.cfg.pie  <= 1'b0;
            st_q.cfg.sqw  <= 1'b0;
            st_q.evt      <= 1'b0;
            st_q.flags    <= 2'b00;
            st_q.sqw_p    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o       = st_q.evt;
    assign flag_set_o  = st_q.flags;
    assign sqw_pulse_o = st_q.sqw_p;

    AST_EVT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        evt_o |-> $past(tick32_i)); // R10
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        evt_o |=> !evt_o); // R10
    AST_CODE0_SILENT: assert property (@(posedge clk) disable iff (rst)
        evt_o |-> ($past(st_q.cfg.rate) != 4'd0)); // R2
    AST_FLAGS_NEED_PIE: assert property (@(posedge clk) disable iff (rst)
        (flag_set_o != 2'b00) |-> ($past(st_q.cfg.pie) && evt_o)); // R7
    AST_SQW_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        sqw_pulse_o |-> ($past(st_q.cfg.sqw) && evt_o)); // R8

endmodule

// File: tb/periodic_rate_gen_tb.sv
module periodic_rate_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick32_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [3:0] rate_i = 4'd0;
    logic       pie_en_i = 1'b0;
    logic       sqw_en_i = 1'b0;
    logic       evt_o;
    logic [1:0] flag_set_o;
    logic       sqw_pulse_o;

    always #2.5 clk = ~clk;

    periodic_rate_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .tick32_i    (tick32_i),
        .cfg_wr_i    (cfg_wr_i),
        .rate_i      (rate_i),
        .pie_en_i    (pie_en_i),
        .sqw_en_i    (sqw_en_i),
        .evt_o       (evt_o),
        .flag_set_o  (flag_set_o),
        .sqw_pulse_o (sqw_pulse_o)
    );

    typedef struct packed {
        logic [3:0]  code;
        logic        pie;
        logic        sqw;
        int unsigned per;
        int unsigned n;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{4'd3,  1'b1, 1'b0, 4,     20},
        '{4'd6,  1'b1, 1'b1, 32,    100},
        '{4'd1,  1'b1, 1'b0, 128,   300},
        '{4'd8,  1'b0, 1'b1, 128,   300},
        '{4'd2,  1'b1, 1'b1, 256,   600},
        '{4'd9,  1'b1, 1'b0, 256,   600},
        '{4'd0,  1'b1, 1'b1, 0,     200},
        '{4'd5,  1'b0, 1'b0, 0,     100},
        '{4'd4,  1'b0, 1'b1, 8,     40},
        '{4'd7,  1'b1, 1'b1, 64,    200},
        '{4'd15, 1'b1, 1'b0, 16384, 17000}
    };

    int          n_chk = 0;
    int          n_bad = 0;
    int unsigned tcount = 0;
    int unsigned m_per = 0;
    logic        m_pie = 1'b0;
    logic        m_sqw = 1'b0;
    bit          done = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (tick count %0d)", tag, act, exp, tcount);
        end
    endtask

    function automatic logic model_evt();
        return (m_per != 0) && (m_pie || m_sqw) && (tcount % m_per == 0);
    endfunction

    task automatic check_outputs(input string tag);
        logic e;
        e = model_evt();
        check(tag, int'(evt_o), int'(e));
        check("R7", int'(flag_set_o), (e && m_pie) ? 3 : 0);
        check("R8", int'(sqw_pulse_o), int'(e && m_sqw));
    endtask

    task automatic do_tick(input string tag);
        @(negedge clk);
        tick32_i = 1'b1;
        @(negedge clk);
        tick32_i = 1'b0;
        tcount++;
        check_outputs(tag);
    endtask

    task automatic write_cfg(input logic [3:0] c, input logic p, input logic s, input int unsigned per);
        @(negedge clk);
        cfg_wr_i = 1'b1;
        rate_i = c;
        pie_en_i = p;
        sqw_en_i = s;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        m_per = per;
        m_pie = p;
        m_sqw = s;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tick32_i = 1'b0;
        cfg_wr_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        tcount = 0;
        m_per = 32;
        m_pie = 1'b0;
        m_sqw = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: outputs low after reset, default enables clear
        check("R1", int'(evt_o), 0);
        check("R1", int'(flag_set_o), 0);
        check("R1", int'(sqw_pulse_o), 0);
        for (int i = 0; i < 70; i++) begin
            do_tick("R1");
        end

        // table walk: no reset between rows so each row starts mid-count (R9)
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            if (VEC[v].code == 4'd0) tag = "R2";
            else if (!VEC[v].pie && !VEC[v].sqw) tag = "R6";
            else if (VEC[v].code <= 4'd2) tag = "R4";
            else tag = "R3";
            write_cfg(VEC[v].code, VEC[v].pie, VEC[v].sqw, VEC[v].per);
            for (int k = 0; k < int'(VEC[v].n); k++) begin
                do_tick((k == 0) ? "R9" : tag);
            end
        end

        // R5 / R10: align onto an event, then idle cycles stay quiet
        do_reset();
        write_cfg(4'd3, 1'b1, 1'b1, 4);
        for (int i = 0; i < 4; i++) begin
            do_tick("R5");
        end
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R10", int'(evt_o), 0);
            check("R10", int'(sqw_pulse_o), 0);
        end

        // R11: tick reaching a multiple together with a write of code 0
        for (int i = 0; i < 3; i++) begin
            do_tick("R5");
        end
        @(negedge clk);
        tick32_i = 1'b1;
        cfg_wr_i = 1'b1;
        rate_i = 4'd0;
        pie_en_i = 1'b1;
        sqw_en_i = 1'b0;
        @(negedge clk);
        tick32_i = 1'b0;
        cfg_wr_i = 1'b0;
        tcount++;
        check("R11", int'(evt_o), 1);
        check("R11", int'(flag_set_o), 3);
        m_per = 0;
        m_pie = 1'b1;
        m_sqw = 1'b0;
        for (int i = 0; i < 8; i++) begin
            do_tick("R2");
        end

        // R1: reset mid-period restarts the count
        write_cfg(4'd3, 1'b1, 1'b0, 4);
        do_tick("R5");
        do_tick("R5");
        do_reset();
        write_cfg(4'd3, 1'b1, 1'b0, 4);
        do_tick("R1");
        do_tick("R1");
        check("R1", int'(evt_o), 0);
        do_tick("R1");
        do_tick("R1");
        check("R1", int'(evt_o), 1);

        finish_run();
    end

endmodule